// File: doc/BRIEF.md
# DDR SDRAM Command Sequence Checker

This block sits beside a DDR SDRAM controller and watches the command pins it drives. On every rising clock edge it decodes chip select, the three strobe pins, the bank bits and the address bus into one command. It keeps an open/idle flag and the last opened row for each bank. It also follows the delay-locked loop state through extended mode register writes and self-refresh exits. When a command breaks the sequencing rules, it raises a one-cycle violation pulse with a numeric error code.

Two wait windows are tracked with down-counters. The first starts after every mode register load: only no-operation and deselect cycles may fill it. The second starts whenever the delay-locked loop goes from off to on: no READ may land inside it. Data timing, refresh intervals and drive electrics are not examined. The drive-strength bit of the extended register is ignored.

Command encoding, as chip select, row strobe, column strobe and write enable (active low): 1xxx deselect, 0111 no-operation, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode register load, 0110 burst stop.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: An activate opens the bank named by `ba`. After the sampling edge, `bank_open[ba]` reads 1 and that bank's field of `bank_row` (bits `ba*13 +: 13`) holds the `addr` value of the activate.
- R2: An activate to a bank that is already open gives error code 1, whatever the row.
- R3: A precharge with `addr[10]`=0 closes only the bank named by `ba`. With `addr[10]`=1 it closes all banks.
- R4: A mode register load while any bank is open gives error code 2.
- R5: After a mode register load, any command other than no-operation or deselect issued fewer than `TMRD` (default 2) cycles later gives error code 3. The same command issued `TMRD` or more cycles later does not.
- R6: A load with `ba`=1 writes the extended register: `addr[0]`=0 turns the delay-locked loop on and `addr[0]`=1 turns it off. A load with `ba`=0 leaves the loop state unchanged. Neither turning on an already-on loop nor `addr[1]` starts a relock wait.
- R7: When the loop goes from off to on, a READ issued fewer than `RELOCK` (default 200) cycles later gives error code 4. A READ issued exactly `RELOCK` cycles later gives no error.
- R8: A refresh sampled with `cke` low enters self refresh. The first later edge with `cke` high exits it, turns the loop on and starts the same `RELOCK` wait.
- R9: A READ or WRITE to an idle bank gives error code 5.
- R10: No-operation and deselect cycles raise no violation, leave the bank flags unchanged and neither restart nor hold any wait counter.
- R11: Only one code is reported per command, with this priority: 3 first, then 1, 2 or 4, then 5. `viol` is high for exactly the cycle after the offending edge, and `viol_code` is 0 whenever `viol` is low.
- R12: During and right after reset, all banks are idle, the loop is on, no wait is pending and `viol` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, used for self-refresh entry and exit |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row / mode-register address bus |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Error code (0 when no violation) |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 52 | Last activated row per bank, 13 bits each |

## Verification
Every result is registered once. A command sampled at edge N shows up on `viol`, `viol_code`, `bank_open` and `bank_row` just after edge N. The bench drives each command on a falling edge, waits for the next rising edge, then samples one time unit later, so each check reads the response to exactly that command. The wait windows are swept by placing the tested command at known distances from the load or the relock start. The distance is counted in the bench, and the expected code comes from comparing it with `TMRD` or `RELOCK`.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_LMR,
    CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ACT_OPEN = 3'd1,
    ERR_LMR_BUSY = 3'd2,
    ERR_MRD      = 3'd3,
    ERR_RELOCK   = 3'd4,
    ERR_IDLE_ACC = 3'd5
  } err_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = CMD_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_LMR;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  localparam int SW   = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act,
  input  logic                pre,
  input  logic                pre_all,
  input  logic [SW-1:0]       sel,
  input  logic [ROW_W-1:0]    row_in,
  output logic [NB-1:0]       open_o,
  output logic [NB*ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             hit;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    assign hit = (sel == SW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (act && hit) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end else if (pre && (pre_all || hit)) begin
        open_q <= 1'b0;
      end
    end

    assign open_o[b]                  = open_q;
    assign rows_o[b*ROW_W +: ROW_W]   = row_q;
  end
endmodule

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int WAIT = 2,
  localparam int CW  = $clog2(WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CW'(WAIT - 1);
    else if (clear)           cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int TMRD      = 2,
  parameter int RELOCK    = 200,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int AP_BIT   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic                       viol,
  output logic [2:0]                 viol_code,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
  cmd_e cmd;
  err_e err, err_q;
  logic exec, cur_open;
  logic mrd_busy, relock_busy;
  logic sr_q, sr_enter, sr_exit;
  logic dll_off_q;
  logic emr_load, relock_start, relock_clear;

  ddr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  ddr_bank_table #(.NB(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act(cmd == CMD_ACT), .pre(cmd == CMD_PRE), .pre_all(addr[AP_BIT]),
    .sel(ba), .row_in(addr),
    .open_o(bank_open), .rows_o(bank_row)
  );

  ddr_wait_timer #(.WAIT(TMRD)) u_mrd (
    .clk(clk), .rst_n(rst_n), .start(cmd == CMD_LMR), .clear(1'b0), .busy(mrd_busy)
  );

  ddr_wait_timer #(.WAIT(RELOCK)) u_relock (
    .clk(clk), .rst_n(rst_n), .start(relock_start), .clear(relock_clear),
    .busy(relock_busy)
  );

  assign exec     = (cmd != CMD_NOP) && (cmd != CMD_DESEL);
  assign cur_open = bank_open[ba];
  assign emr_load = (cmd == CMD_LMR) && (ba == BA_W'(1));
  assign sr_enter = (cmd == CMD_REF) && !cke && !sr_q;
  assign sr_exit  = sr_q && cke;

  assign relock_start = sr_exit || (emr_load && !addr[0] && dll_off_q);
  assign relock_clear = emr_load && addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= 1'b0;
      dll_off_q <= 1'b0;
    end else begin
      if (sr_enter)     sr_q <= 1'b1;
      else if (sr_exit) sr_q <= 1'b0;
      if (sr_exit)       dll_off_q <= 1'b0;
      else if (emr_load) dll_off_q <= addr[0];
    end
  end

  always_comb begin
    err = ERR_NONE;
    if (exec && mrd_busy) err = ERR_MRD;
    else begin
      case (cmd)
        CMD_ACT: if (cur_open)     err = ERR_ACT_OPEN;
        CMD_LMR: if (|bank_open)   err = ERR_LMR_BUSY;
        CMD_RD: begin
          if (relock_busy)         err = ERR_RELOCK;
          else if (!cur_open)      err = ERR_IDLE_ACC;
        end
        CMD_WR:  if (!cur_open)    err = ERR_IDLE_ACC;
        default: err = ERR_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= ERR_NONE;
    else        err_q <= err;
  end

  assign viol      = (err_q != ERR_NONE);
  assign viol_code = err_q;
endmodule

// File: rtl/ddr_mon_checker.sv
module ddr_mon_checker #(
  parameter int NUM_BANKS = 4,
  parameter int TMRD      = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic                 a10,
  input logic                 viol,
  input logic [2:0]           viol_code,
  input logic [NUM_BANKS-1:0] bank_open
);
  logic is_idle, is_act, is_pre, is_lmr, lmr_q;

  assign is_idle = cs_n || ({ras_n, cas_n, we_n} == 3'b111);
  assign is_act  = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
  assign is_pre  = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);
  assign is_lmr  = !cs_n && ({ras_n, cas_n, we_n} == 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) lmr_q <= 1'b0;
    else        lmr_q <= is_lmr;
  end

  assert_code_when_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0 && viol_code <= 3'd5));
  assert_quiet_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_code == 3'd0);
  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> bank_open[$past(ba)]);
  assert_act_on_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && bank_open[ba]) |=> viol);
  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |=> bank_open == '0);
  assert_lmr_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lmr && |bank_open) |=> viol);
  assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (TMRD > 1 && lmr_q && !is_idle) |=> viol);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> (!viol && $stable(bank_open)));
endmodule

bind ddr_cmd_monitor ddr_mon_checker #(.NUM_BANKS(NUM_BANKS), .TMRD(TMRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .a10(addr[10]), .viol(viol), .viol_code(viol_code), .bank_open(bank_open)
);

// File: tb/ddr_cmd_monitor_test.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_test;
  localparam int NB = 4, RW = 13, TMRD = 2, RELOCK = 200;
  localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
    C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic viol;
  logic [2:0] viol_code;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] bank_row;

  ddr_cmd_monitor #(.NUM_BANKS(NB), .ROW_W(RW), .TMRD(TMRD), .RELOCK(RELOCK)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .viol(viol), .viol_code(viol_code),
    .bank_open(bank_open), .bank_row(bank_row)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] c, int b, int a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b[1:0];
    addr = a[RW-1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic expect_code(string req, int code);
    check(req, int'(viol_code), code);
    check(req, int'(viol), int'(code != 0));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(C_NOP, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 viol", int'(viol), 0);
    check("R12 banks", int'(bank_open), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2: open every bank, then re-open
    for (int b = 0; b < NB; b++) begin
      issue(C_ACT, b, b * 1000 + 7);
      expect_code("R1 act", 0);
      check("R1 open", int'(bank_open), (1 << (b + 1)) - 1);
      check("R1 row", int'(bank_row[b*RW +: RW]), b * 1000 + 7);
      issue(C_ACT, b, 55);
      expect_code("R2 reopen", 1);
    end

    // R10: deselect / nop with busy-looking pins
    issue(C_DES, 2, 1024);
    expect_code("R10 deselect", 0);
    check("R10 banks", int'(bank_open), 4'hF);
    issue(C_NOP, 1, 1024);
    check("R10 nop banks", int'(bank_open), 4'hF);

    // R3 single precharge, R9 idle accesses
    issue(C_PRE, 1, 0);
    check("R3 single", int'(bank_open), 4'b1101);
    issue(C_WR, 1, 0);  expect_code("R9 write idle", 5);
    issue(C_RD, 1, 0);  expect_code("R9 read idle", 5);
    issue(C_RD, 2, 0);  expect_code("R9 read open", 0);
    issue(C_WR, 3, 0);  expect_code("R9 write open", 0);

    // R4 load with banks open, R11 priority of code 3 over code 1
    issue(C_LMR, 0, 0); expect_code("R4 load busy", 2);
    issue(C_ACT, 0, 3); expect_code("R11 prio 3 over 1", 3);
    issue(C_NOP, 0, 0); expect_code("R11 pulse one cycle", 0);
    issue(C_PRE, 0, 1024);
    expect_code("R3 all", 0);
    check("R3 all banks", int'(bank_open), 0);

    // R5 / R10 sweep of the gap after a load
    for (int g = 0; g < 4; g++) begin
      issue(C_LMR, 0, 0);
      expect_code("R5 load", 0);
      for (int i = 0; i < g; i++) issue((i % 2) ? C_DES : C_NOP, 0, 0);
      issue(C_ACT, 0, g);
      expect_code("R5 gap", (g + 1 < TMRD) ? 3 : 0);
      issue(C_PRE, 0, 0);
      expect_code("R5 pre", 0);
    end

    // R6 / R7: turn loop off then on, sweep READ distance
    issue(C_LMR, 1, 1); expect_code("R6 off", 0);
    idle(1);
    issue(C_LMR, 1, 0); expect_code("R6 on", 0);
    for (int k = 1; k <= RELOCK + 5; k++) begin
      if (k == 2) begin
        issue(C_ACT, 0, 9); expect_code("R7 act", 0);
      end else if (k == 3 || k == 120 || k == RELOCK - 1 || k == RELOCK || k == RELOCK + 5) begin
        issue(C_RD, 0, 0);
        expect_code("R7 read", (k < RELOCK) ? 4 : 0);
      end else issue(C_NOP, 0, 0);
    end

    // R6: base register and already-on loop start no wait
    issue(C_PRE, 0, 1024);
    issue(C_LMR, 0, 1); expect_code("R6 base", 0);
    idle(1);
    issue(C_LMR, 1, 2); expect_code("R6 on again", 0);
    idle(1);
    issue(C_ACT, 0, 4);
    issue(C_RD, 0, 0); expect_code("R6 no relock", 0);

    // R8 self refresh exit
    issue(C_PRE, 0, 1024);
    cke = 1'b0;
    issue(C_REF, 0, 0); expect_code("R8 enter", 0);
    idle(3);
    cke = 1'b1;
    issue(C_NOP, 0, 0);
    for (int k = 1; k <= RELOCK + 1; k++) begin
      if (k == 3) begin
        issue(C_RD, 0, 0); expect_code("R11 prio 4 over 5", 4);
      end else if (k == 4) begin
        issue(C_WR, 0, 0); expect_code("R9 write idle", 5);
      end else if (k == 5) begin
        issue(C_ACT, 0, 1);
      end else if (k == RELOCK - 1 || k == RELOCK) begin
        issue(C_RD, 0, 0); expect_code("R8 read", (k < RELOCK) ? 4 : 0);
      end else issue(C_NOP, 0, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule